// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Source Controller

This block keeps the per-source state for a bank of interrupt inputs and turns their activity into presentation records for a downstream presentation controller. Each input is fixed at build time as either edge-triggered (message style) or level-sensitive. Every source holds a destination server and a priority. A priority of all ones masks the source. A record carries the server, the global interrupt number and the priority.

The presentation controller answers with three commands. Reject hands an interrupt back. End-of-interrupt (EOI) retires one. Resend-all asks the block to offer again whatever it still owes. A configuration write port sets a source's server and priority. Edge sources keep a rejected flag and a masked-pending flag. Level sources keep an asserted flag and a sent flag. Each command acts on the two kinds in its own way. Records leave one per cycle on a valid/ready handshake.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no record is offered and every source is masked, so activity on any input leaves `pres_valid` low.
- R2: Source index i has global number NUM_BASE+i. A configuration write or a command whose number lies outside [NUM_BASE, NUM_BASE+NUM_SRC) changes no state.
- R3: A source whose priority is all ones (0xFF at the default width) is never offered.
- R4: An unmasked edge source with no pending state offers one record, holding its configured server and priority, in the cycle after its input is seen rising.
- R5: An edge source that rises while masked records a masked-pending flag. The next configuration write with an unmasked priority clears the flag and offers the source once. Masking an edge source whose record is still waiting converts that record into masked-pending.
- R6: A level source is re-evaluated when its input changes, when it is configured and on resend-all. On re-evaluation it is offered only if it is unmasked, asserted and not already sent, and offering it sets the sent flag. Masking a level source whose record is still waiting withdraws the record.
- R7: Reject (`cmd_op`=2'b01) sets the source's rejected flag and clears its sent flag, whatever its kind. A rejected level source is not offered again until its next re-evaluation.
- R8: EOI (`cmd_op`=2'b10) clears the sent flag of a level source and does not re-evaluate it. On an edge source EOI has no effect.
- R9: Resend-all (`cmd_op`=2'b11, `cmd_num` ignored) clears the rejected flag of every rejected edge source and offers each one that is unmasked, exactly once. It also re-evaluates every level source. `cmd_op`=2'b00 does nothing.
- R10: At most one record is offered per cycle, and the lowest-indexed waiting source goes first. A waiting record stays offered until `pres_ready` takes it, and no waiting source is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Synchronous interrupt inputs, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_num | input | NUM_W | Global number of the source being configured |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority; all ones masks the source |
| cmd_valid | input | 1 | Command strobe from the presentation controller |
| cmd_op | input | 2 | 00 none, 01 reject, 10 EOI, 11 resend-all |
| cmd_num | input | NUM_W | Global number the command refers to |
| pres_valid | output | 1 | A record is offered |
| pres_ready | input | 1 | The presentation controller takes the record |
| pres_server | output | SRV_W | Server of the offered record |
| pres_num | output | NUM_W | Global number of the offered record |
| pres_prio | output | PRIO_W | Priority of the offered record |

## Verification
The bench sweeps every source of a configuration with four edge and four level sources. Each source gets its own server and priority, derived from its index, so a record sent to the wrong slot shows up in the fields. The sweep covers five patterns:
- Inputs toggled while masked, which separates the masked-pending path of edge sources from level sources, which latch nothing.
- Writes to numbers just below and just above the valid range, which expose a wrong offset or an address that wraps.
- Reject, EOI and resend applied to each kind, which show whether the rejected and sent flags are kept apart per kind.
- Several edges rising in the same cycle with ready held low, which checks ordering by index and that a waiting record is held.
- Masking a record while it waits and then unmasking it.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
   typedef enum logic [1:0] {
      CMD_NOP    = 2'b00,
      CMD_REJECT = 2'b01,
      CMD_EOI    = 2'b10,
      CMD_RESEND = 2'b11
   } cmd_e;
endpackage

// File: rtl/irq_num_decode.sv
module irq_num_decode #(
   parameter int NUM_SRC  = 8,
   parameter int NUM_BASE = 16,
   parameter int NUM_W    = 8
) (
   input  logic             en,
   input  logic [NUM_W-1:0] num,
   output logic [NUM_SRC-1:0] hit
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      assign hit[i] = en && (num == NUM_W'(NUM_BASE + i));
   end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int NUM_SRC = 8,
   localparam int IDX_W  = $clog2(NUM_SRC > 1 ? NUM_SRC : 2)
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter int SRV_W    = 4,
   parameter int PRIO_W   = 8,
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_lvl,
   input  logic              cfg_hit,
   input  logic [SRV_W-1:0]  cfg_server,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic              rej_hit,
   input  logic              eoi_hit,
   input  logic              resend,
   input  logic              grant,
   output logic              req,
   output logic [SRV_W-1:0]  server,
   output logic [PRIO_W-1:0] prio
);
   localparam logic [PRIO_W-1:0] MASKED = '1;

   logic asr, sent, rej, mpend;
   logic n_asr, n_sent, n_rej, n_mpend, n_req, n_open;
   logic [SRV_W-1:0]  n_server;
   logic [PRIO_W-1:0] n_prio;

   always_comb begin
      n_server = server;
      n_prio   = prio;
      n_rej    = rej;
      n_mpend  = mpend;
      n_sent   = sent;
      n_req    = req & ~grant;
      n_asr    = in_lvl;
      if (cfg_hit) begin
         n_server = cfg_server;
         n_prio   = cfg_prio;
      end
      if (rej_hit) begin
         n_rej  = 1'b1;
         n_sent = 1'b0;
      end
      if (eoi_hit && IS_LEVEL) n_sent = 1'b0;
      n_open = (n_prio != MASKED);
      if (IS_LEVEL) begin
         if (cfg_hit && !n_open && n_req) begin
            n_req  = 1'b0;
            n_sent = 1'b0;
         end
         if ((cfg_hit || resend || (in_lvl != asr)) && n_open && n_asr && !n_sent) begin
            n_sent = 1'b1;
            n_req  = 1'b1;
         end
      end else begin
         if (cfg_hit && !n_open && n_req) begin
            n_req   = 1'b0;
            n_mpend = 1'b1;
         end
         if (cfg_hit && n_open && n_mpend) begin
            n_mpend = 1'b0;
            n_req   = 1'b1;
         end
         if (resend && n_rej) begin
            n_rej = 1'b0;
            if (n_open) n_req = 1'b1;
         end
         if (in_lvl && !asr) begin
            if (n_open) n_req = 1'b1;
            else        n_mpend = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         server <= '0;
         prio   <= MASKED;
         asr    <= 1'b0;
         sent   <= 1'b0;
         rej    <= 1'b0;
         mpend  <= 1'b0;
         req    <= 1'b0;
      end else begin
         server <= n_server;
         prio   <= n_prio;
         asr    <= n_asr;
         sent   <= n_sent;
         rej    <= n_rej;
         mpend  <= n_mpend;
         req    <= n_req;
      end
   end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl #(
   parameter int                 NUM_SRC   = 8,
   parameter int                 NUM_BASE  = 16,
   parameter int                 NUM_W     = 8,
   parameter int                 SRV_W     = 4,
   parameter int                 PRIO_W    = 8,
   parameter logic [NUM_SRC-1:0] LEVEL_SRC = 8'hF0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               cfg_we,
   input  logic [NUM_W-1:0]   cfg_num,
   input  logic [SRV_W-1:0]   cfg_server,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [NUM_W-1:0]   cmd_num,
   output logic               pres_valid,
   input  logic               pres_ready,
   output logic [SRV_W-1:0]   pres_server,
   output logic [NUM_W-1:0]   pres_num,
   output logic [PRIO_W-1:0]  pres_prio
);
   import irq_src_pkg::*;

   localparam int IDX_W = $clog2(NUM_SRC > 1 ? NUM_SRC : 2);

   initial begin
      assert (NUM_SRC >= 1) else $fatal(1, "NUM_SRC must be at least 1");
      assert (NUM_BASE + NUM_SRC <= (1 << NUM_W)) else $fatal(1, "numbers exceed NUM_W");
      assert (PRIO_W >= 2 && SRV_W >= 1) else $fatal(1, "field widths too small");
   end

   cmd_e cmd;
   assign cmd = cmd_e'(cmd_op);

   logic [NUM_SRC-1:0] cfg_hit, rej_hit, eoi_hit, req_vec, grant_vec;
   logic [SRV_W-1:0]   srv_arr  [NUM_SRC];
   logic [PRIO_W-1:0]  prio_arr [NUM_SRC];
   logic [IDX_W-1:0]   pick_idx;
   logic               resend, take;

   assign resend = cmd_valid && (cmd == CMD_RESEND);

   irq_num_decode #(.NUM_SRC(NUM_SRC), .NUM_BASE(NUM_BASE), .NUM_W(NUM_W)) u_cfg_dec (
      .en(cfg_we), .num(cfg_num), .hit(cfg_hit));
   irq_num_decode #(.NUM_SRC(NUM_SRC), .NUM_BASE(NUM_BASE), .NUM_W(NUM_W)) u_rej_dec (
      .en(cmd_valid && (cmd == CMD_REJECT)), .num(cmd_num), .hit(rej_hit));
   irq_num_decode #(.NUM_SRC(NUM_SRC), .NUM_BASE(NUM_BASE), .NUM_W(NUM_W)) u_eoi_dec (
      .en(cmd_valid && (cmd == CMD_EOI)), .num(cmd_num), .hit(eoi_hit));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign grant_vec[i] = take && (pick_idx == IDX_W'(i));
      irq_src_cell #(.SRV_W(SRV_W), .PRIO_W(PRIO_W), .IS_LEVEL(LEVEL_SRC[i])) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .in_lvl     (src_in[i]),
         .cfg_hit    (cfg_hit[i]),
         .cfg_server (cfg_server),
         .cfg_prio   (cfg_prio),
         .rej_hit    (rej_hit[i]),
         .eoi_hit    (eoi_hit[i]),
         .resend     (resend),
         .grant      (grant_vec[i]),
         .req        (req_vec[i]),
         .server     (srv_arr[i]),
         .prio       (prio_arr[i])
      );
   end

   irq_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .req(req_vec), .any(pres_valid), .idx(pick_idx));

   assign take        = pres_valid && pres_ready;
   assign pres_server = srv_arr[pick_idx];
   assign pres_prio   = prio_arr[pick_idx];
   assign pres_num    = NUM_W'(NUM_BASE) + NUM_W'(pick_idx);
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
   parameter int NUM_SRC  = 8,
   parameter int NUM_BASE = 16,
   parameter int NUM_W    = 8,
   parameter int PRIO_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              pres_valid,
   input logic              pres_ready,
   input logic [NUM_W-1:0]  pres_num,
   input logic [PRIO_W-1:0] pres_prio
);
   localparam logic [PRIO_W-1:0] MASKED = '1;

   AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      pres_valid |-> pres_prio != MASKED); // R3
   AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pres_valid |-> (pres_num >= NUM_W'(NUM_BASE)) && (pres_num < NUM_W'(NUM_BASE + NUM_SRC))); // R2
   AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      pres_valid && !pres_ready && !cfg_we |=> pres_valid); // R10
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pres_valid); // R1
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .NUM_BASE(NUM_BASE), .NUM_W(NUM_W), .PRIO_W(PRIO_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .pres_valid(pres_valid),
   .pres_ready(pres_ready), .pres_num(pres_num), .pres_prio(pres_prio)
);

// File: tb/irq_src_ctrl_tb.sv
`timescale 1ns/1ps
module irq_src_ctrl_tb;
   localparam int N = 8, BASE = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] src_in = '0;
   logic cfg_we = 1'b0, cmd_valid = 1'b0, pres_ready = 1'b0;
   logic [7:0] cfg_num = '0, cmd_num = '0, cfg_prio = '0;
   logic [3:0] cfg_server = '0;
   logic [1:0] cmd_op = 2'b00;
   logic pres_valid;
   logic [3:0] pres_server;
   logic [7:0] pres_num, pres_prio;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_src_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we), .cfg_num(cfg_num),
      .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_num(cmd_num), .pres_valid(pres_valid), .pres_ready(pres_ready),
      .pres_server(pres_server), .pres_num(pres_num), .pres_prio(pres_prio));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic none(input string tag);
      chk(pres_valid == 1'b0, tag, int'(pres_valid), 0);
   endtask

   task automatic take(input int num, input int srv, input int pr, input string tag);
      chk(pres_valid == 1'b1, {tag, " valid"}, int'(pres_valid), 1);
      chk(pres_num == 8'(num), {tag, " num"}, int'(pres_num), num);
      chk(pres_server == 4'(srv), {tag, " server"}, int'(pres_server), srv);
      chk(pres_prio == 8'(pr), {tag, " prio"}, int'(pres_prio), pr);
      pres_ready = 1'b1;
      @(negedge clk);
      pres_ready = 1'b0;
   endtask

   task automatic cfg(input int num, input int srv, input int pr);
      cfg_we = 1'b1; cfg_num = 8'(num); cfg_server = 4'(srv); cfg_prio = 8'(pr);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cmd(input logic [1:0] op, input int num);
      cmd_valid = 1'b1; cmd_op = op; cmd_num = 8'(num);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic pin(input int i, input logic v);
      src_in[i] = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      none("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      none("R1 after reset");
      // R1: every source masked after reset
      src_in = '1; @(negedge clk); @(negedge clk);
      none("R1 masked inputs");
      src_in = '0; @(negedge clk);
      // R2: out-of-range writes must not unmask the pending edge sources
      cfg(BASE - 1, 2, 3); none("R2 number below range");
      cfg(BASE + N, 2, 3); none("R2 number above range");
      // R5: masked edges left masked-pending; unmasking offers each once
      for (int i = 0; i < 4; i++) begin
         cfg(BASE + i, i + 1, 10 + i);
         take(BASE + i, i + 1, 10 + i, "R5 pending edge");
         none("R5 offered once");
      end
      // R4: edge sweep
      for (int i = 0; i < 4; i++) begin
         pin(i, 1'b1);
         take(BASE + i, i + 1, 10 + i, "R4 edge");
         none("R4 single record");
         pin(i, 1'b0);
      end
      // R6/R8/R9: level sweep
      for (int i = 4; i < N; i++) begin
         cfg(BASE + i, i + 1, 10 + i);
         none("R6 unasserted level");
         pin(i, 1'b1);
         take(BASE + i, i + 1, 10 + i, "R6 level");
         none("R6 sent blocks repeat");
         cmd(2'b10, BASE + i);
         none("R8 eoi no re-evaluation");
         cmd(2'b11, 0);
         take(BASE + i, i + 1, 10 + i, "R9 level resend");
         pin(i, 1'b0);
         cmd(2'b10, BASE + i);
         cmd(2'b11, 0);
         none("R9 deasserted level");
      end
      // R10: lowest index first, held while not ready
      src_in[0] = 1'b1; src_in[2] = 1'b1; src_in[3] = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk(pres_valid && pres_num == 8'(BASE), "R10 held lowest", int'(pres_num), BASE);
      take(BASE, 1, 10, "R10 first");
      take(BASE + 2, 3, 12, "R10 second");
      take(BASE + 3, 4, 13, "R10 third");
      none("R10 drained");
      src_in = '0; @(negedge clk);
      // R7/R9: edge reject and resend
      pin(1, 1'b1);
      take(BASE + 1, 2, 11, "R7 edge first");
      pin(1, 1'b0);
      cmd(2'b01, BASE + 1); none("R7 edge reject");
      cmd(2'b11, 0); take(BASE + 1, 2, 11, "R9 edge resend");
      cmd(2'b11, 0); none("R9 rejected flag cleared");
      cmd(2'b00, BASE + 1); none("R9 no-op command");
      // R8: EOI on edge has no effect
      pin(3, 1'b1);
      take(BASE + 3, 4, 13, "R8 edge");
      pin(3, 1'b0);
      cmd(2'b10, BASE + 3); none("R8 edge eoi");
      cmd(2'b11, 0); none("R8 edge not rejected");
      // R5: masking a waiting edge record
      pin(2, 1'b1);
      cfg(BASE + 2, 3, 255); none("R5 masked while waiting");
      cfg(BASE + 2, 3, 7); take(BASE + 2, 3, 7, "R5 unmask restores");
      pin(2, 1'b0);
      // R7: level reject
      pin(5, 1'b1);
      take(BASE + 5, 6, 15, "R7 level first");
      cmd(2'b01, BASE + 5); none("R7 level reject waits");
      cmd(2'b01, BASE + N); none("R2 reject out of range");
      cmd(2'b11, 0); take(BASE + 5, 6, 15, "R7 level after resend");
      none("R7 level sent again");
      pin(5, 1'b0);
      // R6: masking a waiting level record
      pin(6, 1'b1);
      cfg(BASE + 6, 7, 255); none("R6 mask withdraws");
      cfg(BASE + 6, 7, 9); take(BASE + 6, 7, 9, "R6 unmask re-evaluates");
      pin(6, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule